// File: doc/BRIEF.md
# Control-word variable-frequency tick generator

This block turns a 16-bit control word into a rate that is a fixed fraction of the reference clock. Each channel holds a 16-bit phase accumulator. While the channel runs, the accumulator gains an increment derived from the control word on every reference cycle. Each carry out of the accumulator gives one tick, and that tick serves as the clock enable of a downstream constant-frequency PWM stage. The top bit of the accumulator is also brought out as a square wave at the same rate.

The control word arrives as two byte-wide register values, an upper byte and a lower byte, which software writes separately. The word is read as signed. A value below 0x8000 is used as it stands. A value of 0x8000 or above is replaced by its 16-bit two's-complement magnitude. The channel takes up a new word only at an accumulator wrap, so a half-written word never reaches the output as a rate. The channel also takes up a new word while it is stopped, and while its active increment is zero. Stopping a channel clears its accumulator. The number of channels is a parameter.

Top module: `cwtg_top`

## Requirements
- R1: During and after reset, with run low, every tick and square-wave output is 0.
- R2: The increment W is the control word when the word is below 0x8000. Otherwise W is (65536 - word) mod 65536. For example, 0xFF00 gives the same rate as 0x0100.
- R3: From a cleared accumulator, a running channel gives exactly floor(N*W/65536) ticks over its first N reference cycles. The maximum word 0x8000 gives a tick on every second cycle.
- R4: A tick is high for exactly one cycle. It appears on the cycle after the edge at which the accumulator sum reached or passed 65536, and two ticks never fall in consecutive cycles.
- R5: The square-wave output equals bit 15 of the accumulator, and the accumulator holds (k*W) mod 65536 after k running cycles from clear.
- R6: For a power-of-two word, the square wave is high for exactly half of each output period.
- R7: A control word of 0 gives no ticks and holds the square wave low.
- R8: A change of the byte inputs while the channel runs with a nonzero increment takes effect only at the cycle after the next accumulator wrap. Up to that wrap, the old rate holds.
- R9: With run low, the channel clears its accumulator and loads the byte inputs as its active word. One cycle after run goes low, both outputs are 0.
- R10: Each channel has its own word, run and accumulator, and one channel has no effect on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_hi_i | input | 8*NUM_CH | Upper control-word byte for each channel, channel c in bits [8c+7:8c] |
| cw_lo_i | input | 8*NUM_CH | Lower control-word byte for each channel, same packing as the upper byte |
| run_i | input | NUM_CH | Run enable for each channel |
| tick_o | output | NUM_CH | One-cycle clock-enable pulse for each channel |
| sq_o | output | NUM_CH | Square wave for each channel (accumulator bit 15) |

## Verification
The bench tests the signed-word rule by pairing 0xFF00 with 0x0100. A design that used the raw word as the increment would run many times too fast at 0xFF00. The maximum word 0x8000 must give alternating ticks, and the zero word must stay silent. A design that mishandled the carry would double-pulse at the maximum word or drift at the zero word. The bench writes the upper byte first and the lower byte some cycles later, both inside an output period. It then checks that the first tick keeps the old spacing and the next tick uses only the final word. A design that took up bytes at once would tick early at the intermediate rate. The bench also stops a channel in mid-period to show that the accumulator is cleared. A leftover phase would shift the first tick after restart.

// File: rtl/cwtg_pkg.sv
package cwtg_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CW_W   = 2 * BYTE_W;
    localparam int unsigned HALF   = 1 << (CW_W - 1);

    typedef logic [CW_W-1:0] cword_t;
    typedef logic [CW_W:0]   csum_t;

    typedef struct packed {
        cword_t word;
    } shadow_state_t;

    typedef struct packed {
        cword_t acc;
        logic   tick;
    } acc_state_t;

    // Signed reading of a control word: below half-scale as is, else magnitude.
    function automatic cword_t cw_magnitude(input cword_t w);
        cword_t m;
        if (w[CW_W-1] == 1'b0) begin
            m = w;
        end else begin
            m = ~w + cword_t'(1);
        end
        return m;
    endfunction

endpackage

// File: rtl/cwtg_word_shadow.sv
module cwtg_word_shadow
    import cwtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wrap_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    output cword_t            inc_o
);

    shadow_state_t st_d, st_q;
    cword_t        in_word;
    cword_t        inc;
    logic          load;

    always_comb begin
        st_d    = st_q;
        in_word = {hi_i, lo_i};
        inc     = cw_magnitude(st_q.word);
        load    = !run_i || wrap_i || (inc == '0);
        if (load) begin
            st_d.word = in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_o = inc;

    // R8: while running with a live increment and no wrap, the active word holds
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_i && (inc_o != '0)) |=> $stable(inc_o));

endmodule

// File: rtl/cwtg_phase_acc.sv
module cwtg_phase_acc
    import cwtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  cword_t inc_i,
    output logic   wrap_o,
    output logic   tick_o,
    output logic   sq_o
);

    acc_state_t st_d, st_q;
    csum_t      sum;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, inc_i};
        wrap = run_i && sum[CW_W];
        if (run_i) begin
            st_d.acc  = sum[CW_W-1:0];
            st_d.tick = wrap;
        end else begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = wrap;
    assign tick_o = st_q.tick;
    assign sq_o   = st_q.acc[CW_W-1];

    // R4: a tick is never followed by another tick
    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R9: stopping clears the phase and the tick
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!tick_o && !sq_o));

    // R7: a zero increment from a cleared phase stays silent
    p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i == '0 && !sq_o && !tick_o && !wrap_o) |=> !tick_o);

    // R3: increment never exceeds half-scale, so a carry cannot repeat at once
    p_inc_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/cwtg_top.sv
module cwtg_top
    import cwtg_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*BYTE_W-1:0] cw_hi_i,
    input  logic [NUM_CH*BYTE_W-1:0] cw_lo_i,
    input  logic [NUM_CH-1:0]        run_i,
    output logic [NUM_CH-1:0]        tick_o,
    output logic [NUM_CH-1:0]        sq_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cword_t inc;
        logic   wrap;

        cwtg_word_shadow u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run_i[c]),
            .wrap_i (wrap),
            .hi_i   (cw_hi_i[c*BYTE_W +: BYTE_W]),
            .lo_i   (cw_lo_i[c*BYTE_W +: BYTE_W]),
            .inc_o  (inc)
        );

        cwtg_phase_acc u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run_i[c]),
            .inc_i  (inc),
            .wrap_o (wrap),
            .tick_o (tick_o[c]),
            .sq_o   (sq_o[c])
        );
    end

endmodule

// File: tb/cwtg_top_test.sv
module cwtg_top_test;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH*8-1:0] hi = '0;
    logic [NCH*8-1:0] lo = '0;
    logic [NCH-1:0] run = '0;
    logic [NCH-1:0] tick;
    logic [NCH-1:0] sq;

    int errors = 0;
    int checks = 0;
    int m_acc  [NCH];
    int m_word [NCH];
    int m_tick [NCH];
    int ticks  [NCH];
    int highs  [NCH];

    always #4 clk = ~clk;

    cwtg_top #(.NUM_CH(NCH)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cw_hi_i (hi),
        .cw_lo_i (lo),
        .run_i   (run),
        .tick_o  (tick),
        .sq_o    (sq)
    );

    function automatic int mag(input int w);
        return (w < 32768) ? w : ((65536 - w) % 65536);
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // One reference cycle: model update at the edge, compare after it.
    task automatic step();
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            int inw;
            int w;
            int s;
            inw = {hi[c*8 +: 8], lo[c*8 +: 8]};
            if (!rst_n) begin
                m_acc[c] = 0; m_word[c] = 0; m_tick[c] = 0;
            end else if (!run[c]) begin
                m_acc[c] = 0; m_tick[c] = 0; m_word[c] = inw;
            end else begin
                w = mag(m_word[c]);
                s = m_acc[c] + w;
                m_tick[c] = (s >= 65536) ? 1 : 0;
                m_acc[c]  = s % 65536;
                if (m_tick[c] == 1 || w == 0) m_word[c] = inw;
            end
        end
        #2;
        for (int c = 0; c < NCH; c++) begin
            chk($sformatf("R4 tick ch%0d", c), int'(tick[c]), m_tick[c]);
            chk($sformatf("R5 sq ch%0d", c), int'(sq[c]), (m_acc[c] >> 15) & 1);
            ticks[c] += int'(tick[c]);
            highs[c] += int'(sq[c]);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NCH; c++) begin
            ticks[c] = 0; highs[c] = 0;
        end
    endtask

    task automatic setw(input int c, input int w);
        hi[c*8 +: 8] = 8'(w >> 8);
        lo[c*8 +: 8] = 8'(w);
    endtask

    task automatic stop_load(input int w0, input int w1);
        run = '0;
        setw(0, w0);
        setw(1, w1);
        cycles(2);
        run = '1;
        clear_counts();
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 0; m_word[c] = 0; m_tick[c] = 0;
        end
        clear_counts();
        cycles(3);
        // R1: outputs low in reset
        chk("R1 tick in reset", int'(tick), 0);
        chk("R1 sq in reset", int'(sq), 0);
        rst_n = 1'b1;
        cycles(3);
        chk("R1 tick after reset", int'(tick), 0);
        chk("R1 sq after reset", int'(sq), 0);

        // R3 rate and R10 independent channels
        stop_load(16'h0100, 16'h0040);
        cycles(4096);
        chk("R3 ticks 0x0100 over 4096", ticks[0], 16);
        chk("R10 ticks ch1 0x0040 over 4096", ticks[1], 4);

        // R2 signed reading: 0xFF00 runs as 0x0100
        stop_load(16'hFF00, 16'h0000);
        cycles(4096);
        chk("R2 ticks 0xFF00 over 4096", ticks[0], 16);
        chk("R7 ticks zero word ch1", ticks[1], 0);
        chk("R7 sq highs zero word ch1", highs[1], 0);

        // R3 maximum word
        stop_load(16'h8000, 16'hFFFF);
        cycles(4096);
        chk("R3 ticks 0x8000 over 4096", ticks[0], 2048);
        chk("R2 ticks 0xFFFF over 4096", ticks[1], 0);

        // R6 duty for a power-of-two word
        stop_load(16'h0400, 16'h0000);
        cycles(640);
        chk("R6 sq high cycles 0x0400 over 640", highs[0], 320);
        chk("R3 ticks 0x0400 over 640", ticks[0], 10);

        // R8 byte-wise update takes effect at the next wrap only
        stop_load(16'h0100, 16'h0000);
        cycles(100);
        hi[7:0] = 8'h03;
        cycles(20);
        lo[7:0] = 8'h80;
        cycles(135);
        chk("R8 no early tick before cycle 256", ticks[0], 0);
        cycles(1);
        chk("R8 first tick at old spacing", ticks[0], 1);
        cycles(73);
        chk("R8 no tick at intermediate rate", ticks[0], 1);
        cycles(1);
        chk("R8 second tick uses final word", ticks[0], 2);

        // R9 stop clears phase mid-period
        cycles(30);
        run[0] = 1'b0;
        cycles(1);
        chk("R9 sq after stop", int'(sq[0]), 0);
        chk("R9 tick after stop", int'(tick[0]), 0);
        run[0] = 1'b1;
        clear_counts();
        cycles(73);
        chk("R9 restart no early tick", ticks[0], 0);
        cycles(1);
        chk("R9 restart tick from cleared phase", ticks[0], 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule